// File: doc/BRIEF.md
# SPI serial EEPROM slave engine

This block is the serial front end of a small byte-organised nonvolatile memory. The SPI pins (chip select, serial clock and serial data in) are brought into a faster system clock through two-flop synchronisers. Their edges are detected in that domain. A one-byte command is decoded, a 16-bit address is gathered, and then one of two things happens: read data is streamed out with an auto-incrementing address, or write data is gathered into a page latch. The serial output comes with a separate drive enable for a tri-state pad.

A command that changes state is committed only when chip select returns high after exactly the right number of clock edges. Committed writes start a timed internal cycle, during which a busy output is held high. The memory is an internal register array that is set to all ones at reset. Status-register storage and protect decisions belong to a neighbouring protect block. The engine exchanges single-cycle strobes and level flags with that block.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, so_oe is 0, busy_o is 0 and every array byte reads 0xFF.
- R2: SPI clock modes 0 and 3 both work. SI is sampled on a rising SCK edge and SO changes after a falling SCK edge. so_oe is 0 whenever cs_n is high.
- R3: The first byte after cs_n falls is the command, MSB first, with these codes: 0x06 sets write enable (pulse wren_o), 0x04 clears it (pulse wrdi_o), 0x05 reads status, 0x01 writes status, 0x03 reads memory and 0x02 writes memory.
- R4: With any other command code, so_oe stays 0 and no strobe, busy period or array change follows, until cs_n goes high.
- R5: Memory read and write take a 16-bit address in the second and third bytes, high byte first. Only the low ADDR_W bits are used. The first read byte is shifted out MSB first from the falling edge after clock 24.
- R6: A read keeps streaming while clocks continue. The address increments after each byte and wraps from 2^ADDR_W-1 to 0.
- R7: Write data goes into a page latch of 2^PAGE_W bytes. Only the low PAGE_W address bits advance, so extra bytes wrap and overwrite earlier ones. Page bytes that were not received keep their old contents.
- R8: Commit happens only if cs_n rises after exactly the expected number of rising SCK edges: 8 for the write-enable set or clear, 16 for status write, and 24+8m (m>=1) for memory write. Any other count leaves the block's state unchanged.
- R9: A memory write commits only when wel_i=1, busy_o=0 and prot_deny_i=0 for the address on wr_addr_o. A status write commits only when wel_i=1, busy_o=0 and sr_lock_i=0.
- R10: A committed write holds busy_o high for exactly WR_CYCLES system clocks. The hold starts the cycle after commit, and wr_done_o pulses in the last busy cycle.
- R11: A memory read or write command received while busy_o=1 is not accepted: so_oe stays 0. Status reads still work, with bit 0 equal to 1.
- R12: A status read sends {stat_hi_i, busy_o} (bit 0 = busy) MSB first, again every 8 clocks while cs_n stays low.
- R13: wren_o, wrdi_o and sr_wr_o are single-cycle and mutually exclusive. sr_data_o carries the received status byte while sr_wr_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Drive enable for so |
| stat_hi_i | input | 7 | Status bits 7:1 from the protect block |
| wel_i | input | 1 | Write-enable latch state |
| prot_deny_i | input | 1 | Protect block refuses a write at wr_addr_o |
| sr_lock_i | input | 1 | Status register is write-locked |
| wr_addr_o | output | ADDR_W | Current address, for the protect decision |
| wren_o | output | 1 | Write-enable set strobe |
| wrdi_o | output | 1 | Write-enable clear strobe |
| sr_wr_o | output | 1 | Status write commit strobe |
| sr_data_o | output | 8 | Status byte received |
| busy_o | output | 1 | Internal write cycle in progress |
| wr_done_o | output | 1 | Last cycle of the internal write |

## Verification
The hardest situation to reach is a command that arrives while an internal write is still running. The bench therefore sets a long write time and closes the write transfer without waiting. It then issues a status read and a memory read back to back, so both land inside the busy window. The other awkward cases are transfers cut off one bit early or late, and page writes that run past the page end. These are produced by directed partial-byte transfers and a 35-byte write. Random writes and readbacks in both clock modes are then compared against a bench memory model.

// File: rtl/ee_pkg.sv
// Package: shared command type and decoder for the SPI EEPROM engine.
// Assumes the command byte is complete before decoding.
package ee_pkg;

    typedef enum logic [2:0] {
        OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE, OP_DEAD
    } ee_op_e;

    // Map a command byte to an operation; array access is refused while busy.
    function automatic ee_op_e ee_decode(input logic [7:0] code, input logic busy);
        case (code)
            8'h06:   return OP_WREN;
            8'h04:   return OP_WRDI;
            8'h05:   return OP_RDSR;
            8'h01:   return OP_WRSR;
            8'h03:   return busy ? OP_DEAD : OP_READ;
            8'h02:   return busy ? OP_DEAD : OP_WRITE;
            default: return OP_DEAD;
        endcase
    endfunction

endpackage

// File: rtl/ee_sync.sv
// Two-flop synchroniser bank for asynchronous pins.
// Each bit resets to its own value from RST_VAL; no edge logic here.
module ee_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] st;
        // Shift the pin through two stages.
        always_ff @(posedge clk) begin
            if (!rst_n) st <= {2{RST_VAL[g]}};
            else        st <= {st[0], din[g]};
        end
        assign q[g] = st[1];
    end
endmodule

// File: rtl/ee_timer.sv
// Internal write-cycle timer: busy for exactly N cycles after a start pulse.
// Assumes start is never given while busy.
module ee_timer #(
    parameter int N = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(N + 1);
    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(N);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy);
    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);
endmodule

// File: rtl/ee_array.sv
// Byte array with one read port and a masked whole-page write port.
// Filled with 0xFF at reset; page index = high address bits.
module ee_array #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [7:0]                       rd_data,
    input  logic                             we,
    input  logic [ADDR_W-PAGE_W-1:0]         page_base,
    input  logic [(1<<PAGE_W)-1:0][7:0]      wdata,
    input  logic [(1<<PAGE_W)-1:0]           wmask
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PG    = 1 << PAGE_W;
    logic [7:0] mem [DEPTH];

    // Reset fill, then write every marked byte of the page at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            for (int j = 0; j < PG; j++)
                if (wmask[j]) mem[{page_base, PAGE_W'(j)}] <= wdata[j];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_eeprom_engine.sv
// SPI slave engine for a byte-wide nonvolatile memory model.
// Oversamples cs_n/sck/si with clk (clk >= 4x sck). Commands commit on a
// cs_n rise at an exact clock count; protect state lives outside.
module spi_eeprom_engine
    import ee_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic [6:0]        stat_hi_i,
    input  logic              wel_i,
    input  logic              prot_deny_i,
    input  logic              sr_lock_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wren_o,
    output logic              wrdi_o,
    output logic              sr_wr_o,
    output logic [7:0]        sr_data_o,
    output logic              busy_o,
    output logic              wr_done_o
);
    localparam int PG     = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic [2:0] pins_s;
    logic cs_s, sck_s, si_s, cs_p, sck_p;
    logic sck_r, sck_f, cs_up;

    ee_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({cs_n, sck, si}), .q(pins_s)
    );
    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign si_s  = pins_s[0];

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p  <= 1'b1;
            sck_p <= 1'b0;
        end else begin
            cs_p  <= cs_s;
            sck_p <= sck_s;
        end
    end
    assign sck_r = sck_s & ~sck_p;
    assign sck_f = ~sck_s & sck_p;
    assign cs_up = cs_s & ~cs_p;

    ee_op_e                op;
    logic [2:0]            bit_cnt, byte_cnt;
    logic [6:0]            shreg;
    logic [7:0]            addr_hi, out_sh, rd_data, rd_src, byte_in;
    logic [ADDR_W-1:0]     addr;
    logic [PAGE_W-1:0]     col;
    logic [PG-1:0][7:0]    pg_data;
    logic [PG-1:0]         pg_mask;
    logic                  drive_q, load_now, at_bound;
    logic                  cm_write, cm_wrsr, start;

    assign byte_in  = {shreg, si_s};
    assign at_bound = (bit_cnt == 3'd0);
    assign load_now = at_bound && ((op == OP_RDSR) || (op == OP_READ && byte_cnt >= 3'd3));
    assign rd_src   = (op == OP_RDSR) ? {stat_hi_i, busy_o} : rd_data;

    // Serial state: shift in on rising SCK, shift out on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op <= OP_NONE; bit_cnt <= '0; byte_cnt <= '0; shreg <= '0;
            addr_hi <= '0; addr <= '0; col <= '0; pg_data <= '0;
            pg_mask <= '0; out_sh <= '0; drive_q <= 1'b0;
        end else if (cs_s) begin
            op <= OP_NONE; bit_cnt <= '0; byte_cnt <= '0;
            pg_mask <= '0; drive_q <= 1'b0;
        end else begin
            if (sck_r) begin
                shreg   <= byte_in[6:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 1'b1;
                    case (byte_cnt)
                        3'd0: op <= ee_decode(byte_in, busy_o);
                        3'd1: addr_hi <= byte_in;
                        3'd2: begin
                            addr <= ADDR_W'({addr_hi, byte_in});
                            col  <= byte_in[PAGE_W-1:0];
                        end
                        default: if (op == OP_WRITE) begin
                            pg_data[col] <= byte_in;
                            pg_mask[col] <= 1'b1;
                            col          <= col + 1'b1;
                        end
                    endcase
                end
            end
            if (sck_f) begin
                if (load_now) begin
                    out_sh  <= rd_src;
                    drive_q <= 1'b1;
                    if (op == OP_READ) addr <= addr + 1'b1;
                end else begin
                    out_sh <= {out_sh[6:0], 1'b0};
                end
            end
        end
    end

    // Commit decisions on the chip-select rise.
    assign wren_o   = cs_up && op == OP_WREN && byte_cnt == 3'd1 && at_bound;
    assign wrdi_o   = cs_up && op == OP_WRDI && byte_cnt == 3'd1 && at_bound;
    assign cm_wrsr  = cs_up && op == OP_WRSR && byte_cnt == 3'd2 && at_bound
                      && wel_i && !busy_o && !sr_lock_i;
    assign cm_write = cs_up && op == OP_WRITE && byte_cnt >= 3'd4 && at_bound
                      && wel_i && !busy_o && !prot_deny_i;
    assign start     = cm_wrsr | cm_write;
    assign sr_wr_o   = cm_wrsr;
    assign sr_data_o = addr_hi;
    assign wr_addr_o = addr;
    assign so        = out_sh[7];
    assign so_oe     = ~cs_n & drive_q;

    ee_timer #(.N(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_o), .done(wr_done_o)
    );

    ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
        .we(cm_write), .page_base(addr[ADDR_W-1:PAGE_W]),
        .wdata(pg_data), .wmask(pg_mask)
    );

    logic [BASE_W-1:0] unused_base;
    assign unused_base = addr[ADDR_W-1:PAGE_W];

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_o, wrdi_o, sr_wr_o, cm_write}));
    // R2
    so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && cs_p) |-> !drive_q);
    // R4
    dead_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_q && op == OP_DEAD));
    // R9
    write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_write |-> (wel_i && !busy_o));
endmodule

// File: tb/spi_eeprom_engine_bench.sv
module spi_eeprom_engine_bench;
    localparam int CLK_P = 10;
    localparam int H     = 6;
    localparam int AW    = 10;
    localparam int PW    = 5;
    localparam int WRC   = 1000;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, so_oe, wel_i, prot_deny_i, sr_lock_i;
    logic wren_o, wrdi_o, sr_wr_o, busy_o, wr_done_o;
    logic [6:0] stat_hi_i;
    logic [AW-1:0] wr_addr_o;
    logic [7:0] sr_data_o;

    spi_eeprom_engine #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) u_spi_eeprom_engine (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
        .stat_hi_i(stat_hi_i), .wel_i(wel_i), .prot_deny_i(prot_deny_i), .sr_lock_i(sr_lock_i),
        .wr_addr_o(wr_addr_o), .wren_o(wren_o), .wrdi_o(wrdi_o), .sr_wr_o(sr_wr_o),
        .sr_data_o(sr_data_o), .busy_o(busy_o), .wr_done_o(wr_done_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Protect-block model (environment): write-enable latch and status bits.
    logic [7:0] sr_m, sr_pend;
    logic wel_m, pend_v, wp_n = 1'b1;
    always @(posedge clk) begin
        if (!rst_n) begin
            sr_m <= 8'h00; wel_m <= 1'b0; pend_v <= 1'b0; sr_pend <= 8'h00;
        end else begin
            if (wren_o) wel_m <= 1'b1;
            if (wrdi_o) wel_m <= 1'b0;
            if (sr_wr_o) begin sr_pend <= sr_data_o & 8'h8C; pend_v <= 1'b1; end
            if (wr_done_o) begin
                wel_m <= 1'b0;
                if (pend_v) sr_m <= sr_pend;
                pend_v <= 1'b0;
            end
        end
    end
    function automatic logic deny_f(input logic [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'd0: return 1'b0;
            2'd1: return a >= AW'(DEPTH*3/4);
            2'd2: return a >= AW'(DEPTH/2);
            default: return 1'b1;
        endcase
    endfunction
    assign stat_hi_i   = {sr_m[7:2], wel_m};
    assign wel_i       = wel_m;
    assign prot_deny_i = deny_f(sr_m[3:2], wr_addr_o);
    assign sr_lock_i   = sr_m[7] & ~wp_n;

    int n_chk = 0, n_bad = 0;
    logic [7:0] ref_mem [DEPTH];
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];
    logic oe_all, oe_seen;
    logic [7:0] e_sr = 8'h00;
    logic e_wel = 1'b0;
    int bl;
    logic [7:0] q;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_begin(input bit m3);
        sck = m3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0; oe_all = 1'b1; oe_seen = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic tx_bits(input logic [7:0] d, input int nb, output logic [7:0] qo);
        qo = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            sck = 1'b0; si = d[i];
            repeat (H) @(negedge clk);
            qo[i] = so; oe_all &= so_oe; oe_seen |= so_oe;
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic tx_end(input bit m3, input bit wait_b, output int blen);
        if (!m3) begin sck = 1'b0; repeat (H) @(negedge clk); end
        cs_n = 1'b1; blen = 0;
        if (wait_b) for (int k = 0; k < WRC + 40; k++) begin
            @(negedge clk);
            if (busy_o) blen++;
        end
        else repeat (H) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [7:0] c, input bit m3);
        logic [7:0] d; int b;
        tx_begin(m3); tx_bits(c, 8, d); tx_end(m3, 1'b0, b);
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input bit m3);
        logic [7:0] d; int b;
        tx_begin(m3);
        tx_bits(8'h03, 8, d); tx_bits(a[15:8], 8, d); tx_bits(a[7:0], 8, d);
        oe_all = 1'b1; oe_seen = 1'b0;
        for (int i = 0; i < n; i++) begin tx_bits(8'h00, 8, d); rbuf[i] = d; end
        tx_end(m3, 1'b0, b);
    endtask

    task automatic do_rdsr(input int n, input bit m3);
        logic [7:0] d; int b;
        tx_begin(m3); tx_bits(8'h05, 8, d);
        oe_all = 1'b1; oe_seen = 1'b0;
        for (int i = 0; i < n; i++) begin tx_bits(8'h00, 8, d); rbuf[i] = d; end
        tx_end(m3, 1'b0, b);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input bit m3,
                            input bit wait_b, output int blen);
        logic [7:0] d;
        tx_begin(m3);
        tx_bits(8'h02, 8, d); tx_bits(a[15:8], 8, d); tx_bits(a[7:0], 8, d);
        for (int i = 0; i < n; i++) tx_bits(wbuf[i], 8, d);
        tx_end(m3, wait_b, blen);
    endtask

    task automatic do_wrsr(input logic [7:0] v, output int blen);
        logic [7:0] d;
        tx_begin(1'b0); tx_bits(8'h01, 8, d); tx_bits(v, 8, d); tx_end(1'b0, 1'b1, blen);
    endtask

    // Reference: apply a page write with low-bit wrap.
    task automatic ref_write(input logic [15:0] a, input int n);
        logic [AW-1:0] base = a[AW-1:0];
        logic [PW-1:0] c = a[PW-1:0];
        for (int i = 0; i < n; i++) begin
            ref_mem[{base[AW-1:PW], c}] = wbuf[i];
            c = c + 1'b1;
        end
    endtask

    task automatic chk_read(input string req, input logic [15:0] a, input int n);
        logic [AW-1:0] x = a[AW-1:0];
        for (int i = 0; i < n; i++) begin
            chk(req, rbuf[i], ref_mem[x]);
            x = x + 1'b1;
        end
    endtask

    function automatic logic [7:0] e_stat(input logic busy);
        return {e_sr[7:2], e_wel, busy};
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 so_oe", so_oe, 0);
        chk("R1 busy", busy_o, 0);
        do_read(16'h03FE, 4, 1'b0);
        chk("R2 read drives so_oe", oe_all, 1);
        chk_read("R1 erased", 16'h03FE, 4);
        do_rdsr(3, 1'b0);
        for (int i = 0; i < 3; i++) chk("R12 status stream", rbuf[i], e_stat(1'b0));

        do_cmd(8'h06, 1'b0); e_wel = 1'b1;
        do_rdsr(2, 1'b1);
        chk("R3 wren mode3 status", rbuf[0], e_stat(1'b0));
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(16'hFC1E, 3, 1'b0, 1'b1, bl);
        chk("R10 busy length", bl, WRC);
        ref_write(16'hFC1E, 3); e_wel = 1'b0;
        do_read(16'h001E, 3, 1'b0);
        chk_read("R5 R7 high bits ignored, page wrap", 16'h001E, 3);
        do_read(16'h0000, 1, 1'b1);
        chk_read("R7 wrapped byte", 16'h0000, 1);
        do_rdsr(1, 1'b0);
        chk("R10 wel cleared after write", rbuf[0], e_stat(1'b0));

        do_cmd(8'h06, 1'b0);
        wbuf[0] = 8'h5A;
        do_write(16'h03FF, 1, 1'b0, 1'b1, bl);
        ref_write(16'h03FF, 1); e_wel = 1'b0;
        do_read(16'h03FE, 3, 1'b1);
        chk_read("R6 rollover", 16'h03FE, 3);

        wbuf[0] = 8'hAA;
        do_write(16'h0100, 1, 1'b0, 1'b1, bl);
        chk("R9 no wel no busy", bl, 0);
        do_read(16'h0100, 1, 1'b0);
        chk_read("R9 no wel unchanged", 16'h0100, 1);

        tx_begin(1'b0); tx_bits(8'h06, 8, q); tx_bits(8'h00, 1, q); tx_end(1'b0, 1'b0, bl);
        do_rdsr(1, 1'b0);
        chk("R8 wren 9 clocks ignored", rbuf[0], e_stat(1'b0));
        do_cmd(8'h06, 1'b0); e_wel = 1'b1;
        tx_begin(1'b0);
        tx_bits(8'h02, 8, q); tx_bits(8'h01, 8, q); tx_bits(8'h20, 8, q);
        tx_bits(8'h77, 8, q); tx_bits(8'h00, 3, q);
        tx_end(1'b0, 1'b1, bl);
        chk("R8 write 35 clocks no busy", bl, 0);
        do_read(16'h0120, 1, 1'b0);
        chk_read("R8 cancelled write", 16'h0120, 1);
        tx_begin(1'b1); tx_bits(8'h01, 8, q); tx_bits(8'h0C, 8, q); tx_bits(8'h00, 1, q);
        tx_end(1'b1, 1'b1, bl);
        chk("R8 wrsr 17 clocks no busy", bl, 0);
        do_rdsr(1, 1'b0);
        chk("R8 status unchanged", rbuf[0], e_stat(1'b0));

        for (int i = 0; i < 35; i++) wbuf[i] = 8'(i + 8'h40);
        do_write(16'h0040, 35, 1'b1, 1'b1, bl);
        chk("R10 page busy", bl, WRC);
        ref_write(16'h0040, 35); e_wel = 1'b0;
        do_read(16'h0040, 32, 1'b1);
        chk_read("R7 page overwrite", 16'h0040, 32);

        do_cmd(8'h06, 1'b0); e_wel = 1'b1;
        tx_begin(1'b0);
        tx_bits(8'hAB, 8, q); oe_seen = 1'b0;
        tx_bits(8'h06, 8, q); tx_bits(8'h02, 8, q); tx_bits(8'hFF, 8, q);
        tx_end(1'b0, 1'b1, bl);
        chk("R4 so_oe stays low", oe_seen, 0);
        chk("R4 no busy", bl, 0);
        do_rdsr(1, 1'b0);
        chk("R4 status unchanged", rbuf[0], e_stat(1'b0));

        wbuf[0] = 8'h99;
        do_write(16'h0200, 1, 1'b0, 1'b0, bl);
        do_rdsr(2, 1'b0);
        chk("R11 status during busy", rbuf[1], e_stat(1'b1));
        do_read(16'h0200, 1, 1'b0);
        chk("R11 read refused while busy", oe_seen, 0);
        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
        ref_write(16'h0200, 1); e_wel = 1'b0;
        do_read(16'h0200, 1, 1'b0);
        chk_read("R11 earlier write landed", 16'h0200, 1);

        do_cmd(8'h06, 1'b0);
        do_wrsr(8'h0C, bl);
        chk("R10 wrsr busy", bl, WRC);
        e_sr = 8'h0C; e_wel = 1'b0;
        do_rdsr(1, 1'b0);
        chk("R3 wrsr status", rbuf[0], e_stat(1'b0));
        do_cmd(8'h06, 1'b0); e_wel = 1'b1;
        wbuf[0] = 8'h12;
        do_write(16'h0010, 1, 1'b0, 1'b1, bl);
        chk("R9 protected write refused", bl, 0);
        do_wrsr(8'h88, bl);
        chk("R9 wrsr accepted", bl, WRC);
        e_sr = 8'h88; e_wel = 1'b0;
        do_cmd(8'h06, 1'b0);
        wbuf[0] = 8'h34;
        do_write(16'h0050, 1, 1'b1, 1'b1, bl);
        chk("R9 lower half allowed", bl, WRC);
        ref_write(16'h0050, 1);
        do_cmd(8'h06, 1'b0); e_wel = 1'b1;
        do_write(16'h0250, 1, 1'b0, 1'b1, bl);
        chk("R9 upper half refused", bl, 0);
        wp_n = 1'b0;
        do_wrsr(8'h00, bl);
        chk("R9 locked status write", bl, 0);
        do_rdsr(1, 1'b0);
        chk("R9 status kept", rbuf[0], e_stat(1'b0));
        wp_n = 1'b1;
        do_wrsr(8'h00, bl);
        chk("R9 unlocked status write", bl, WRC);
        e_sr = 8'h00; e_wel = 1'b0;
        do_rdsr(1, 1'b1);
        chk("R12 status cleared", rbuf[0], e_stat(1'b0));
        do_read(16'h0050, 1, 1'b0);
        chk_read("R9 allowed data", 16'h0050, 1);
        do_read(16'h0250, 1, 1'b0);
        chk_read("R9 refused data", 16'h0250, 1);

        for (int it = 0; it < 12; it++) begin
            bit m3 = 1'($urandom);
            bit en = ($urandom % 4) != 0;
            logic [15:0] a = 16'($urandom);
            int n = 1 + int'($urandom % 40);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            if (en) do_cmd(8'h06, m3);
            do_write(a, n, m3, 1'b1, bl);
            chk("R10 R9 random busy", bl, en ? WRC : 0);
            if (en) ref_write(a, n);
            do_read({a[15:PW], 5'b0}, 32, ~m3);
            chk_read("R7 R2 random readback", {a[15:PW], 5'b0}, 32);
        end
        summary();
    end
endmodule